// File: doc/BRIEF.md
# Select Line Qualifier with Abort Generation

This block sits between the raw active-low chip select of a serial converter and the rest of its control logic. It samples the select line with the conversion clock and passes a change on only after it has persisted across two consecutive clock edges. Glitches narrower than a clock period therefore never reach the control logic. Any assertion that lasts longer than a few periods is always seen.

Each qualified activation of the select emits a one-cycle start pulse that begins a new serial exchange. An activation that arrives while the neighbouring logic reports a conversion or exchange in flight also emits a one-cycle abort pulse. That abort marks the held result as untrustworthy. The result is marked valid again only when the conversion engine signals that a full conversion has finished. Deasserting the select never aborts anything. It only drops the qualified level.

Top module: `cs_qualifier`

## Requirements
- R1: A level change on `cs_n_raw` that is set up before a rising clock edge appears on `sel_q` right after the third rising edge, counting that edge as the first. `sel_q` is 1 when the select is active, meaning `cs_n_raw` is 0.
- R2: A change of `cs_n_raw` that is sampled by at most one rising edge before it reverts has no effect on `sel_q`, `start_pulse`, `abort_pulse` or `data_valid`. Any pulse shorter than one clock period falls in this case.
- R3: A change of `cs_n_raw` that is sampled by two or more consecutive rising edges is always recognized. Any pulse longer than three clock periods falls in this case.
- R4: `start_pulse` is high for exactly one cycle, in the same cycle that `sel_q` goes from 0 to 1, and at no other time.
- R5: `abort_pulse` is high for exactly one cycle, together with `start_pulse`, when `op_active` is 1 at the edge where the activation is recognized. It is never high otherwise.
- R6: A qualified deactivation, where `sel_q` goes from 1 to 0, produces neither `start_pulse` nor `abort_pulse`.
- R7: `data_valid` is 0 after reset. It goes to 0 in the cycle of an abort and goes to 1 one edge after `conv_done` is sampled high. If both occur at the same edge, the abort wins.
- R8: During and right after reset, `sel_q`, `start_pulse` and `abort_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock; everything samples on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_raw | input | 1 | Unfiltered active-low select from the pin |
| op_active | input | 1 | High while a conversion or exchange is in progress |
| conv_done | input | 1 | One-cycle marker that a full conversion has completed |
| sel_q | output | 1 | Qualified select level, 1 when active |
| start_pulse | output | 1 | One-cycle pulse on each qualified activation |
| abort_pulse | output | 1 | One-cycle pulse on an activation during an operation |
| data_valid | output | 1 | The held result comes from an uninterrupted conversion |

## Verification
The hardest situations to reach from the pins are the ones where a select strobe straddles exactly one or exactly two sampling edges. The outcome changes between those two widths. The stimulus therefore sweeps strobe widths of one to six periods, in both polarities and with the operation flag both low and high. It also adds sub-period glitches that fall between two edges.

A second hard case is an abort recognized at the same edge as a completion marker. The bench reaches it by raising `conv_done` exactly during the third edge after a select drop, because that edge is where the design recognizes the activation.

// File: rtl/cs_qualifier.sv
module cs_qualifier (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_raw,
  input  logic op_active,
  input  logic conv_done,
  output logic sel_q,
  output logic start_pulse,
  output logic abort_pulse,
  output logic data_valid
);

  logic samp_a, samp_b, qual_n;
  logic agree, act_edge, kill;

  assign agree    = (samp_a == samp_b);
  assign act_edge = agree & qual_n & ~samp_b;
  assign kill     = act_edge & op_active;
  assign sel_q    = ~qual_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_a <= 1'b1;
      samp_b <= 1'b1;
      qual_n <= 1'b1;
    end else begin
      samp_a <= cs_n_raw;
      samp_b <= samp_a;
      if (agree) qual_n <= samp_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_pulse <= 1'b0;
      abort_pulse <= 1'b0;
      data_valid  <= 1'b0;
    end else begin
      start_pulse <= act_edge;
      abort_pulse <= kill;
      if (kill)           data_valid <= 1'b0;
      else if (conv_done) data_valid <= 1'b1;
    end
  end

endmodule

// File: rtl/cs_qualifier_chk.sv
module cs_qualifier_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n_raw,
  input logic op_active,
  input logic conv_done,
  input logic sel_q,
  input logic start_pulse,
  input logic abort_pulse,
  input logic data_valid
);

  a_r1_rise_needs_two_lows: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_q) |-> (!$past(cs_n_raw, 2) && !$past(cs_n_raw, 3)));

  a_r3_fall_needs_two_highs: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_q) |-> ($past(cs_n_raw, 2) && $past(cs_n_raw, 3)));

  a_r4_start_with_rise: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> $rose(sel_q));

  a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);

  a_r5_abort_with_start: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> (start_pulse && $past(op_active)));

  a_r6_no_pulse_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_q) |-> (!start_pulse && !abort_pulse));

  a_r7_abort_clears_valid: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> !data_valid);

  a_r7_valid_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_valid) |-> $past(conv_done));

endmodule

bind cs_qualifier cs_qualifier_chk u_chk (.*);

// File: tb/tb_cs_qualifier.sv
`timescale 1ns/1ps
module tb_cs_qualifier;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n_raw = 1'b1;
  logic op_active = 1'b0;
  logic conv_done = 1'b0;
  logic sel_q, start_pulse, abort_pulse, data_valid;

  int checks = 0;
  int fails = 0;
  int n_start = 0;
  int n_abort = 0;
  bit done = 1'b0;

  cs_qualifier dut (
    .clk(clk), .rst_n(rst_n), .cs_n_raw(cs_n_raw), .op_active(op_active),
    .conv_done(conv_done), .sel_q(sel_q), .start_pulse(start_pulse),
    .abort_pulse(abort_pulse), .data_valid(data_valid)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (start_pulse) n_start++;
    if (abort_pulse) n_abort++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic negs(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe(input bit level, input int w, input bit act);
    int s0, a0;
    s0 = n_start;
    a0 = n_abort;
    op_active = act;
    cs_n_raw = level;
    negs(w);
    cs_n_raw = ~level;
    negs(8);
    if (level == 1'b0) begin
      check(w >= 2 ? "R3 low strobe" : "R2 low strobe", n_start - s0, (w >= 2) ? 1 : 0);
      check("R5 low strobe abort", n_abort - a0, (w >= 2 && act) ? 1 : 0);
      check("R6 returns inactive", int'(sel_q), 0);
    end else begin
      check(w >= 2 ? "R3 high strobe" : "R2 high strobe", n_start - s0, (w >= 2) ? 1 : 0);
      check("R5 high strobe abort", n_abort - a0, (w >= 2 && act) ? 1 : 0);
      check("R6 stays active", int'(sel_q), 1);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    negs(3);
    check("R8 sel_q in reset", int'(sel_q), 0);
    check("R8 start in reset", int'(start_pulse), 0);
    check("R7 valid in reset", int'(data_valid), 0);
    rst_n = 1'b1;
    negs(4);
    check("R8 sel_q after reset", int'(sel_q), 0);
    check("R8 abort after reset", int'(abort_pulse), 0);

    // R1 latency, activation and deactivation
    cs_n_raw = 1'b0;
    negs(2);
    check("R1 not yet at two", int'(sel_q), 0);
    negs(1);
    check("R1 active at three", int'(sel_q), 1);
    check("R4 start with rise", int'(start_pulse), 1);
    negs(1);
    check("R4 start one cycle", int'(start_pulse), 0);
    cs_n_raw = 1'b1;
    negs(2);
    check("R1 still active at two", int'(sel_q), 1);
    negs(1);
    check("R1 inactive at three", int'(sel_q), 0);
    check("R6 no start on fall", int'(start_pulse), 0);
    negs(4);

    // R2 sub-period glitches that avoid every edge
    for (int k = 0; k < 4; k++) begin
      int s0;
      s0 = n_start;
      @(negedge clk);
      #3 cs_n_raw = 1'b0;
      #5 cs_n_raw = 1'b1;
      negs(6);
      check("R2 narrow glitch ignored", n_start - s0, 0);
      check("R2 sel_q unchanged", int'(sel_q), 0);
    end

    // Width sweep, low strobes from inactive
    for (int act = 0; act < 2; act++)
      for (int w = 1; w <= 6; w++) strobe(1'b0, w, act[0]);

    // Width sweep, high strobes while active
    op_active = 1'b0;
    cs_n_raw = 1'b0;
    negs(6);
    for (int act = 0; act < 2; act++)
      for (int w = 1; w <= 6; w++) strobe(1'b1, w, act[0]);
    op_active = 1'b0;
    cs_n_raw = 1'b1;
    negs(6);

    // R7 valid flag sequence
    conv_done = 1'b1;
    negs(1);
    conv_done = 1'b0;
    check("R7 set by conv_done", int'(data_valid), 1);
    op_active = 1'b1;
    cs_n_raw = 1'b0;
    negs(3);
    check("R5 abort pulse", int'(abort_pulse), 1);
    check("R7 cleared by abort", int'(data_valid), 0);
    negs(1);
    check("R5 abort one cycle", int'(abort_pulse), 0);
    cs_n_raw = 1'b1;
    negs(6);
    conv_done = 1'b1;
    negs(1);
    conv_done = 1'b0;
    check("R7 set again", int'(data_valid), 1);
    cs_n_raw = 1'b0;
    negs(2);
    conv_done = 1'b1;
    negs(1);
    conv_done = 1'b0;
    check("R7 abort wins over done", int'(data_valid), 0);
    check("R5 abort at tie", int'(abort_pulse), 1);
    negs(1);
    conv_done = 1'b1;
    negs(1);
    conv_done = 1'b0;
    check("R7 recovers after done", int'(data_valid), 1);
    op_active = 1'b0;
    negs(4);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule